// File: doc/BRIEF.md
# UART Bit-Timing Tick Generator

This block produces the two timing enables that a UART transmitter and receiver need. It counts a reference clock down to a sample tick, and then counts sample ticks down to a baud tick that marks one bit period. Every output is a one-cycle enable on the single reference clock. No derived clock is produced.

The clock source is chosen by a select input. It is either every reference cycle, or every eighth reference cycle through a divide-by-8 prescaler that acts as a clock enable. A 16-bit clock divisor sets how many source cycles make one sample tick. A bit divisor sets how many sample ticks make one baud tick. The resulting rate is source / (CD × (BDIV+1)). For example, a 50 MHz source with CD = 62 and BDIV = 6 gives about 115207 baud, and the divided source with CD = 81 and BDIV = 7 gives about 9645 baud.

Any change to a configuration field restarts the whole divider chain, so the new rate starts from a clean period. Dropping the run enable holds the chain cleared.

Top module: `uart_baud_gen`

## Requirements
- R1: With `src_div8` = 0 and `clk_div` = N ≥ 2, `sample_tick` is high for exactly one cycle every N clock cycles.
- R2: With `src_div8` = 1, the source advances once every 8 clock cycles, so `sample_tick` repeats every 8 × N clock cycles (8 cycles when N = 1).
- R3: `baud_tick` repeats every (B+1) sample ticks, where B is the effective bit divisor, and it is only ever high in a cycle in which `sample_tick` is also high.
- R4: `clk_div` = 0 stops both ticks: neither `sample_tick` nor `baud_tick` is ever asserted.
- R5: `clk_div` = 1 with `src_div8` = 0 bypasses the clock divisor: `sample_tick` is high in every cycle.
- R6: A `bit_div` value below 4 is treated as 4, so the baud period is then 5 sample ticks.
- R7: A change to any of `src_div8`, `clk_div` or `bit_div` clears all counters at the next clock edge and suppresses any tick that would have issued at that edge. In reference mode, the first `sample_tick` is then seen N+1 cycles after the change is applied.
- R8: While `run_en` is low, no tick is issued and the counters are held cleared. Raising `run_en` again restores the programmed periods.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables tick generation; low holds the counters cleared |
| src_div8 | input | 1 | Source select: 0 = every reference cycle, 1 = every eighth reference cycle |
| clk_div | input | 16 | Clock divisor N; 0 stops the ticks, 1 bypasses the divisor |
| bit_div | input | 4 | Bit divisor B; the baud tick comes every B+1 sample ticks, with B at least 4 |
| sample_tick | output | 1 | One-cycle sample enable, every N source cycles |
| baud_tick | output | 1 | One-cycle bit-period enable, coincident with a sample tick |

## Verification
Two events can fall in the same cycle. The first is a sample tick completing the last group of a bit period, which must raise `sample_tick` and `baud_tick` together. The bench judges this pairing at every sampled cycle and measures both periods for each table row. The second is a configuration change landing in the very cycle a sample tick is about to issue. The bench finds that cycle by counting from the previous tick and writes a new divisor there. It then expects no tick in the following cycle and a first tick exactly N+1 cycles after the change.

// File: rtl/uart_baud_gen_pkg.sv
package uart_baud_gen_pkg;

  // Source selection encoding for the divider chain
  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DIV8 = 1'b1
  } src_sel_e;

  // Fixed prescale ratio of the divided source
  localparam int PRESCALE_DIV = 8;

  // Smallest number of samples per bit minus one that is allowed
  localparam int BIT_DIV_FLOOR = 4;

endpackage

// File: rtl/ubg_prescale.sv
module ubg_prescale
  import uart_baud_gen_pkg::*;
#(
  parameter int DIV = PRESCALE_DIV
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  src_sel_e sel,
  output logic     src_en
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pre_cnt;

  // Counts only when the divided source is selected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (clear || sel == SRC_REF) begin
      pre_cnt <= '0;
    end else if (pre_cnt == LAST) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign src_en = (sel == SRC_REF) ? 1'b1 : (pre_cnt == LAST);

endmodule

// File: rtl/ubg_cd_counter.sv
module ubg_cd_counter #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            src_en,
  input  logic [CD_W-1:0] div,
  output logic            fire,
  output logic [CD_W-1:0] cnt
);

  logic active;

  // Terminal count of a divisor: one less than the divisor itself
  function automatic logic [CD_W-1:0] term_of(input logic [CD_W-1:0] d);
    return d - 1'b1;
  endfunction

  assign active = !clear && (div != '0) && src_en;
  assign fire   = active && (cnt == term_of(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (active) begin
      cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ubg_bd_counter.sv
module ubg_bd_counter
  import uart_baud_gen_pkg::*;
#(
  parameter int BD_W  = 4,
  parameter int FLOOR = BIT_DIV_FLOOR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            sample_fire,
  input  logic [BD_W-1:0] div,
  output logic            fire,
  output logic [BD_W-1:0] cnt,
  output logic [BD_W-1:0] eff
);

  localparam logic [BD_W-1:0] FLOOR_V = BD_W'(FLOOR);

  // Raise small divisors to the floor so each bit has enough samples
  function automatic logic [BD_W-1:0] clamp_div(input logic [BD_W-1:0] d);
    return (d < FLOOR_V) ? FLOOR_V : d;
  endfunction

  assign eff  = clamp_div(div);
  assign fire = !clear && sample_fire && (cnt == eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (sample_fire) begin
      cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_gen_pkg::*;
#(
  parameter int CD_W = 16,
  parameter int BD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            src_div8,
  input  logic [CD_W-1:0] clk_div,
  input  logic [BD_W-1:0] bit_div,
  output logic            sample_tick,
  output logic            baud_tick
);

  // Held copy of the configuration, used to detect a change
  logic            src_q;
  logic [CD_W-1:0] cd_q;
  logic [BD_W-1:0] bd_q;

  // Named internal events for the checker
  logic            cfg_change;
  logic            chain_clear;
  logic            src_en;
  logic            cd_fire;
  logic            bd_fire;
  logic [CD_W-1:0] cd_cnt;
  logic [BD_W-1:0] bd_cnt;
  logic [BD_W-1:0] bd_eff;
  src_sel_e        sel;

  assign sel         = src_div8 ? SRC_DIV8 : SRC_REF;
  assign cfg_change  = (src_div8 != src_q) || (clk_div != cd_q) || (bit_div != bd_q);
  assign chain_clear = !run_en || cfg_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      cd_q  <= '0;
      bd_q  <= '0;
    end else begin
      src_q <= src_div8;
      cd_q  <= clk_div;
      bd_q  <= bit_div;
    end
  end

  ubg_prescale #(
    .DIV (PRESCALE_DIV)
  ) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (chain_clear),
    .sel    (sel),
    .src_en (src_en)
  );

  ubg_cd_counter #(
    .CD_W (CD_W)
  ) u_cd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (chain_clear),
    .src_en (src_en),
    .div    (clk_div),
    .fire   (cd_fire),
    .cnt    (cd_cnt)
  );

  ubg_bd_counter #(
    .BD_W  (BD_W),
    .FLOOR (BIT_DIV_FLOOR)
  ) u_bd (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (chain_clear),
    .sample_fire (cd_fire),
    .div         (bit_div),
    .fire        (bd_fire),
    .cnt         (bd_cnt),
    .eff         (bd_eff)
  );

  // Registered outputs: clean one-cycle enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_tick <= 1'b0;
      baud_tick   <= 1'b0;
    end else begin
      sample_tick <= cd_fire;
      baud_tick   <= bd_fire;
    end
  end

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int CD_W = 16,
  parameter int BD_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_en,
  input logic            sample_tick,
  input logic            baud_tick,
  input logic            cfg_change,
  input logic [CD_W-1:0] cd_q,
  input logic [CD_W-1:0] cd_cnt,
  input logic [BD_W-1:0] bd_cnt,
  input logic [BD_W-1:0] bd_eff
);

  // R3: a bit-period enable only comes together with a sample enable
  p_baud_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> sample_tick);

  // R4: a zero divisor keeps the sample enable low
  p_zero_div_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q == '0) |=> !sample_tick);

  // R8: stopped chain issues nothing
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!sample_tick && !baud_tick));

  // R7: a configuration change restarts both counters and drops the tick
  p_change_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (cd_cnt == '0 && bd_cnt == '0 && !sample_tick && !baud_tick));

  // R1: divisor count stays within its period
  p_cd_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_change && cd_q != '0) |-> (cd_cnt < cd_q));

  // R6: bit count stays within the clamped period
  p_bd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_change |-> (bd_cnt <= bd_eff));

endmodule

bind uart_baud_gen uart_baud_gen_chk #(
  .CD_W (CD_W),
  .BD_W (BD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .sample_tick (sample_tick),
  .baud_tick   (baud_tick),
  .cfg_change  (cfg_change),
  .cd_q        (cd_q),
  .cd_cnt      (cd_cnt),
  .bd_cnt      (bd_cnt),
  .bd_eff      (bd_eff)
);

// File: tb/uart_baud_gen_tb.sv
`timescale 1ns/1ps
module uart_baud_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        src_div8 = 1'b0;
  logic [15:0] clk_div = '0;
  logic [3:0]  bit_div = '0;
  logic        sample_tick;
  logic        baud_tick;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  uart_baud_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .src_div8    (src_div8),
    .clk_div     (clk_div),
    .bit_div     (bit_div),
    .sample_tick (sample_tick),
    .baud_tick   (baud_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input bit s, input int cd, input int bd);
    @(negedge clk);
    src_div8 = s;
    clk_div  = 16'(cd);
    bit_div  = 4'(bd);
  endtask

  // Measure the steady sample and baud periods, in clock cycles
  task automatic measure(input int exp_s, input int exp_b, input string req);
    int ls = 0, lb = 0, ns = 0, nb = 0, ps = -1, pb = -1;
    int unpaired = 0;
    int limit = 4 * exp_b + 100;
    for (int i = 0; i < limit && (ns < 3 || nb < 3); i++) begin
      @(negedge clk);
      if (sample_tick) begin
        if (ns > 0) ps = cyc - ls;
        ls = cyc;
        ns++;
      end
      if (baud_tick) begin
        if (nb > 0) pb = cyc - lb;
        lb = cyc;
        nb++;
        if (!sample_tick) unpaired++;
      end
    end
    check(ps == exp_s, {req, " sample period"}, ps, exp_s);
    check(pb == exp_b, {req, " baud period (R3)"}, pb, exp_b);
    check(unpaired == 0, "R3 baud without sample", unpaired, 0);
  endtask

  // Count negedges after a change until the first sample tick
  task automatic first_tick_after(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (sample_tick) break;
    end
  endtask

  // {src_div8, clk_div, bit_div, sample period, baud period}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{0, 5,  4,   5,   25},  // R1
    '{0, 3,  6,   3,   21},  // R1
    '{0, 9,  5,   9,   54},  // R1
    '{0, 62, 6,   62,  434}, // R1
    '{1, 2,  4,   16,  80},  // R2
    '{1, 3,  7,   24,  192}, // R2
    '{0, 7,  1,   7,   35},  // R6 clamp
    '{0, 1,  4,   1,   5}    // R5 bypass
  };

  initial begin
    int cnt;
    int n;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(sample_tick == 1'b0, "R9 sample_tick in reset", int'(sample_tick), 0);
    check(baud_tick == 1'b0, "R9 baud_tick in reset", int'(baud_tick), 0);
    @(negedge clk);
    rst_n  = 1'b1;
    run_en = 1'b1;

    // R4: zero divisor, no ticks
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sample_tick || baud_tick) cnt++;
    end
    check(cnt == 0, "R4 ticks with zero divisor", cnt, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][0] != 0, VEC[v][1], VEC[v][2]);
      measure(VEC[v][3], VEC[v][4], (VEC[v][0] != 0) ? "R2" : "R1");
    end

    // R5: bypass keeps sample_tick high every cycle
    apply(1'b0, 1, 4);
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sample_tick) cnt++;
    end
    check(cnt == 20, "R5 bypass sample count", cnt, 20);

    // R7: latency after change
    apply(1'b0, 6, 4);
    repeat (20) @(negedge clk);
    clk_div = 16'd4;
    first_tick_after(n);
    check(n == 5, "R7 first tick after change", n, 5);

    // R7: change in the cycle a tick would issue suppresses it
    apply(1'b0, 5, 4);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sample_tick) break;
    end
    repeat (4) @(negedge clk);
    clk_div = 16'd7;
    @(negedge clk);
    check(sample_tick == 1'b0, "R7 tick suppressed on change", int'(sample_tick), 0);
    first_tick_after(n);
    check(n + 1 == 8, "R7 first tick after suppressing change", n + 1, 8);

    // R8: run enable low holds everything quiet
    apply(1'b0, 3, 4);
    @(negedge clk);
    run_en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sample_tick || baud_tick) cnt++;
    end
    check(cnt == 0, "R8 ticks while stopped", cnt, 0);
    run_en = 1'b1;
    measure(3, 15, "R8 resume");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule